// File: doc/BRIEF.md
# Byte-Wide Register File with Word FIFO Port

This block sits behind a host-side byte interface that has already been decoded into four single-cycle strobes: address write, address read, data write and data read. An 8-bit pointer register is loaded and read back through the address strobes. Every data strobe then reaches the register that the pointer selects. The register file holds three registers. The control register carries the enable and clear bits for two external FIFOs. The status register reports the flags of both FIFOs and a sticky error bit. The reset register drives a device reset pin and a self-reset of this block.

Two further pointer values act as FIFO windows, because the FIFOs carry 32-bit words while the host moves one byte at a time. Four back-to-back data writes to the command window build one word, least significant byte first, and the word is offered to the command FIFO after the last byte. Four back-to-back data reads from the response window pop one word and return it least significant byte first. If any other data access arrives while such a run is unfinished, the run is cut short and the error bit is set.

Both FIFO ports use valid/ready. The command port raises `cmd_valid` for exactly one cycle per word and never holds it. A word offered while `cmd_ready` is low is discarded, so the host side sees no back-pressure. On the response port, `rsp_valid` means not empty. `rsp_ready` is a single-cycle pop and is raised only when `rsp_valid` is high.

Top module: `hostreg_word_bridge`

## Requirements
- R1: After reset the pointer, control, reset and error state are zero, every enable, clear and reset output is low, and `rd_byte` is 0.
- R2: An address-write strobe loads `wr_byte` into the pointer. An address-read strobe returns the pointer on `rd_byte` in the following cycle. Address strobes never break a FIFO byte run.
- R3: The control register sits at pointer 0x00. Bits 0..3 are levels driving `cmd_wr_en`, `cmd_rd_en`, `rsp_wr_en` and `rsp_rd_en`, and they read back in bits 0..3. Bits 4 and 5 produce a one-cycle `cmd_clr` or `rsp_clr` pulse in the cycle after the write, and they read back as 0.
- R4: A data read of pointer 0x01 returns `{err, 3'b000, rsp_full, !rsp_valid, !cmd_ready, cmd_empty}`.
- R5: Four consecutive data writes to pointer 0x10 with `cmd_wr_en` high raise `cmd_valid` for exactly the one cycle after the fourth write. `cmd_data` then holds the four bytes with the first byte in bits 7:0.
- R6: A completed command word is lost when `cmd_wr_en` is low (no `cmd_valid`) or when `cmd_ready` is low in its valid cycle.
- R7: The first of four consecutive data reads of pointer 0x11 pops one word when `rsp_rd_en` and `rsp_valid` are high. The four reads return that word's bytes, least significant first. Only one pop occurs per four reads.
- R8: When the response FIFO is empty or `rsp_rd_en` is low, a four-read run returns four zero bytes and does not pop.
- R9: Any data access other than the next one in an unfinished run sets the error bit. The run is abandoned, and the next FIFO access starts again at byte 0.
- R10: The error bit is also set by a `proto_err` pulse. It stays set until a data write to 0x01 with bit 7 high clears it. A set request in the same cycle wins.
- R11: Pointer 0x02 holds `dev_rst` in bit 0. Writing bit 1 raises `self_rst` for one cycle, and the cycle after that the block is back in its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Address-cycle write strobe |
| addr_rd | input | 1 | Address-cycle read strobe |
| data_wr | input | 1 | Data-cycle write strobe |
| data_rd | input | 1 | Data-cycle read strobe |
| wr_byte | input | 8 | Host write byte |
| rd_byte | output | 8 | Host read byte, valid the cycle after a read strobe |
| proto_err | input | 1 | Host protocol error pulse |
| cmd_valid | output | 1 | Command word offer, one cycle |
| cmd_ready | input | 1 | Command FIFO not full |
| cmd_data | output | 8*NBYTES | Assembled command word |
| cmd_empty | input | 1 | Command FIFO empty flag |
| rsp_valid | input | 1 | Response FIFO not empty |
| rsp_ready | output | 1 | Response pop |
| rsp_data | input | 8*NBYTES | Response FIFO head word |
| rsp_full | input | 1 | Response FIFO full flag |
| cmd_wr_en | output | 1 | Command FIFO write enable |
| cmd_rd_en | output | 1 | Command FIFO read enable |
| rsp_wr_en | output | 1 | Response FIFO write enable |
| rsp_rd_en | output | 1 | Response FIFO read enable |
| cmd_clr | output | 1 | Command FIFO clear pulse |
| rsp_clr | output | 1 | Response FIFO clear pulse |
| dev_rst | output | 1 | External device reset |
| self_rst | output | 1 | Self-reset pulse |

## Verification
All sixteen enable patterns are written to the control register. This shows that each enable bit drives its own pin and that the clear bits pulse without being stored. All sixteen flag combinations are presented to the status register, which would expose any swapped or inverted flag. The command window is fed words whose four bytes all differ, so a byte-order or lane-shift error shows up as a wrong word. The response window is read across several consecutive words, which tells a correct one-pop-per-four-reads pattern apart from popping on every read. Runs are cut short after one and after two bytes, separating an abandoned run that resumes cleanly from one that leaks stale bytes or misses the error.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CMD  = 2'd1,
    SEQ_RSP  = 2'd2
  } seq_kind_t;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] PTR_CTRL = 8'h00;
  localparam logic [BYTE_W-1:0] PTR_STAT = 8'h01;
  localparam logic [BYTE_W-1:0] PTR_RST  = 8'h02;
  localparam logic [BYTE_W-1:0] PTR_CMDW = 8'h10;
  localparam logic [BYTE_W-1:0] PTR_RSPW = 8'h11;

  localparam int unsigned EN_BITS     = 4;
  localparam int unsigned BIT_CMD_CLR = 4;
  localparam int unsigned BIT_RSP_CLR = 5;
  localparam int unsigned BIT_ERR     = 7;
  localparam int unsigned BIT_DEVRST  = 0;
  localparam int unsigned BIT_SELFRST = 1;
endpackage

// File: rtl/hrf_seq_track.sv
module hrf_seq_track
  import hrf_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          hit_cmd,
  input  logic          hit_rsp,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic          brk,
  output logic          cmd_op,
  output logic          rsp_op
);
  seq_kind_t     kind_q;
  logic [IW-1:0] cnt_q;
  logic          any_op;
  logic          cont;

  always_comb begin
    cmd_op = data_wr & hit_cmd;
    rsp_op = data_rd & ~data_wr & hit_rsp;
    any_op = data_wr | data_rd;
    cont   = ((kind_q == SEQ_CMD) & cmd_op) | ((kind_q == SEQ_RSP) & rsp_op);
    brk    = any_op & (kind_q != SEQ_IDLE) & ~cont;
    idx    = brk ? '0 : cnt_q;
    last   = (idx == IW'(NBYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SEQ_IDLE;
      cnt_q  <= '0;
    end else if (srst) begin
      kind_q <= SEQ_IDLE;
      cnt_q  <= '0;
    end else if (cmd_op | rsp_op) begin
      if (last) begin
        kind_q <= SEQ_IDLE;
        cnt_q  <= '0;
      end else begin
        kind_q <= cmd_op ? SEQ_CMD : SEQ_RSP;
        cnt_q  <= idx + 1'b1;
      end
    end else if (any_op) begin
      kind_q <= SEQ_IDLE;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/hrf_cmd_pack.sv
module hrf_cmd_pack
  import hrf_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         srst,
  input  logic                         cmd_op,
  input  logic [IW-1:0]                idx,
  input  logic                         last,
  input  logic [BYTE_W-1:0]            wr_byte,
  input  logic                         wr_en,
  output logic                         cmd_valid,
  output logic [NBYTES*BYTE_W-1:0]     cmd_data
);
  logic [NBYTES-1:0][BYTE_W-1:0] hold_q;
  logic [NBYTES-1:0][BYTE_W-1:0] asm_w;

  generate
    for (genvar l = 0; l < NBYTES; l++) begin : g_lane
      assign asm_w[l] = (l == NBYTES - 1) ? wr_byte : hold_q[l];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q[l] <= '0;
        else if (srst) hold_q[l] <= '0;
        else if (cmd_op && (idx == IW'(l))) hold_q[l] <= wr_byte;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else if (srst) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else if (cmd_op && last && wr_en) begin
      cmd_valid <= 1'b1;
      cmd_data  <= asm_w;
    end else begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hrf_rsp_unpack.sv
module hrf_rsp_unpack
  import hrf_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srst,
  input  logic                     rsp_op,
  input  logic [IW-1:0]            idx,
  input  logic                     rd_en,
  input  logic                     rsp_valid,
  input  logic [NBYTES*BYTE_W-1:0] rsp_data,
  output logic                     rsp_ready,
  output logic [BYTE_W-1:0]        byte_out
);
  logic [NBYTES-1:0][BYTE_W-1:0] word_q;
  logic [NBYTES-1:0][BYTE_W-1:0] head_w;
  logic                          first;

  assign head_w = rsp_data;

  always_comb begin
    first     = rsp_op & (idx == '0);
    rsp_ready = first & rd_en & rsp_valid;
    if (idx == '0) byte_out = rsp_ready ? head_w[0] : '0;
    else           byte_out = word_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (srst) word_q <= '0;
    else if (first) word_q <= rsp_ready ? head_w : '0;
  end
endmodule

// File: rtl/hrf_ctrl_regs.sv
module hrf_ctrl_regs
  import hrf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_wr,
  input  logic               hit_ctrl,
  input  logic               hit_stat,
  input  logic               hit_rst,
  input  logic [BYTE_W-1:0]  wr_byte,
  input  logic               brk,
  input  logic               proto_err,
  output logic [EN_BITS-1:0] en_q,
  output logic               cmd_clr_q,
  output logic               rsp_clr_q,
  output logic               dev_rst_q,
  output logic               soft_q,
  output logic               err_q
);
  logic wr_ctrl, wr_stat, wr_rst;
  logic err_set, err_clr;

  always_comb begin
    wr_ctrl = data_wr & hit_ctrl;
    wr_stat = data_wr & hit_stat;
    wr_rst  = data_wr & hit_rst;
    err_set = brk | proto_err;
    err_clr = wr_stat & wr_byte[BIT_ERR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      cmd_clr_q <= 1'b0;
      rsp_clr_q <= 1'b0;
      dev_rst_q <= 1'b0;
      soft_q    <= 1'b0;
      err_q     <= 1'b0;
    end else if (soft_q) begin
      en_q      <= '0;
      cmd_clr_q <= 1'b0;
      rsp_clr_q <= 1'b0;
      dev_rst_q <= 1'b0;
      soft_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wr_byte[EN_BITS-1:0];
      cmd_clr_q <= wr_ctrl & wr_byte[BIT_CMD_CLR];
      rsp_clr_q <= wr_ctrl & wr_byte[BIT_RSP_CLR];
      if (wr_rst) dev_rst_q <= wr_byte[BIT_DEVRST];
      soft_q <= wr_rst & wr_byte[BIT_SELFRST];
      if (err_set) err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hostreg_word_bridge.sv
module hostreg_word_bridge
  import hrf_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int unsigned WW = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              addr_rd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic              proto_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WW-1:0]     cmd_data,
  input  logic              cmd_empty,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WW-1:0]     rsp_data,
  input  logic              rsp_full,
  output logic              cmd_wr_en,
  output logic              cmd_rd_en,
  output logic              rsp_wr_en,
  output logic              rsp_rd_en,
  output logic              cmd_clr,
  output logic              rsp_clr,
  output logic              dev_rst,
  output logic              self_rst
);
  logic [BYTE_W-1:0]  addr_q;
  logic               hit_ctrl, hit_stat, hit_rst, hit_cmd, hit_rsp;
  logic [IW-1:0]      idx;
  logic               last, brk, cmd_op, rsp_op;
  logic [EN_BITS-1:0] en_q;
  logic               soft_q, err_flag;
  logic [BYTE_W-1:0]  rsp_byte;
  logic [BYTE_W-1:0]  stat_byte;
  logic [BYTE_W-1:0]  data_mux;

  always_comb begin
    hit_ctrl = (addr_q == PTR_CTRL);
    hit_stat = (addr_q == PTR_STAT);
    hit_rst  = (addr_q == PTR_RST);
    hit_cmd  = (addr_q == PTR_CMDW);
    hit_rsp  = (addr_q == PTR_RSPW);
  end

  hrf_seq_track #(.NBYTES(NBYTES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (soft_q),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .hit_cmd (hit_cmd),
    .hit_rsp (hit_rsp),
    .idx     (idx),
    .last    (last),
    .brk     (brk),
    .cmd_op  (cmd_op),
    .rsp_op  (rsp_op)
  );

  hrf_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .hit_ctrl  (hit_ctrl),
    .hit_stat  (hit_stat),
    .hit_rst   (hit_rst),
    .wr_byte   (wr_byte),
    .brk       (brk),
    .proto_err (proto_err),
    .en_q      (en_q),
    .cmd_clr_q (cmd_clr),
    .rsp_clr_q (rsp_clr),
    .dev_rst_q (dev_rst),
    .soft_q    (soft_q),
    .err_q     (err_flag)
  );

  hrf_cmd_pack #(.NBYTES(NBYTES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (soft_q),
    .cmd_op    (cmd_op),
    .idx       (idx),
    .last      (last),
    .wr_byte   (wr_byte),
    .wr_en     (en_q[0]),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data)
  );

  hrf_rsp_unpack #(.NBYTES(NBYTES)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (soft_q),
    .rsp_op    (rsp_op),
    .idx       (idx),
    .rd_en     (en_q[3]),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ready (rsp_ready),
    .byte_out  (rsp_byte)
  );

  assign cmd_wr_en = en_q[0];
  assign cmd_rd_en = en_q[1];
  assign rsp_wr_en = en_q[2];
  assign rsp_rd_en = en_q[3];
  assign self_rst  = soft_q;

  always_comb begin
    stat_byte = {err_flag, 3'b000, rsp_full, ~rsp_valid, ~cmd_ready, cmd_empty};
    unique case (1'b1)
      hit_ctrl: data_mux = {{(BYTE_W-EN_BITS){1'b0}}, en_q};
      hit_stat: data_mux = stat_byte;
      hit_rst:  data_mux = {{(BYTE_W-1){1'b0}}, dev_rst};
      hit_rsp:  data_mux = rsp_byte;
      default:  data_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_byte <= '0;
    end else if (soft_q) begin
      addr_q  <= '0;
      rd_byte <= '0;
    end else begin
      if (addr_wr) addr_q <= wr_byte;
      if (addr_rd) rd_byte <= addr_q;
      else if (data_rd) rd_byte <= data_mux;
    end
  end
endmodule

// File: rtl/hrf_checker.sv
module hrf_checker
  import hrf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              data_wr,
  input logic [BYTE_W-1:0] addr_q,
  input logic [BYTE_W-1:0] wr_byte,
  input logic              cmd_valid,
  input logic              rsp_ready,
  input logic              rsp_valid,
  input logic              rsp_rd_en,
  input logic              cmd_clr,
  input logic              self_rst,
  input logic              dev_rst,
  input logic              cmd_wr_en,
  input logic              err_flag
);
  assert_offer_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_offer_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(data_wr && addr_q == PTR_CMDW));

  assert_pop_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (rsp_valid && rsp_rd_en));

  assert_clear_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |-> $past(data_wr && addr_q == PTR_CTRL && wr_byte[BIT_CMD_CLR]));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && $past(err_flag)) |->
      $past((data_wr && addr_q == PTR_STAT && wr_byte[BIT_ERR]) || self_rst));

  assert_self_reset_defaults_R11: assert property (@(posedge clk) disable iff (!rst_n)
    self_rst |=> (!dev_rst && !cmd_wr_en && !rsp_rd_en && !err_flag && addr_q == '0));
endmodule

bind hostreg_word_bridge hrf_checker u_hrf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .data_wr   (data_wr),
  .addr_q    (addr_q),
  .wr_byte   (wr_byte),
  .cmd_valid (cmd_valid),
  .rsp_ready (rsp_ready),
  .rsp_valid (rsp_valid),
  .rsp_rd_en (rsp_rd_en),
  .cmd_clr   (cmd_clr),
  .self_rst  (self_rst),
  .dev_rst   (dev_rst),
  .cmd_wr_en (cmd_wr_en),
  .err_flag  (err_flag)
);

// File: tb/test_hostreg_word_bridge.sv
`timescale 1ns/1ps
module test_hostreg_word_bridge;
  localparam int NB = 4;
  localparam logic [7:0] P_CTRL = 8'h00, P_STAT = 8'h01, P_RST = 8'h02,
                         P_CMD = 8'h10, P_RSP = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_wr = 0, addr_rd = 0, data_wr = 0, data_rd = 0, proto_err = 0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] rd_byte;
  logic cmd_valid, rsp_ready;
  logic cmd_ready = 1'b1, cmd_empty = 1'b1, rsp_valid = 1'b0, rsp_full = 1'b0;
  logic [31:0] cmd_data, rsp_data;
  logic cmd_wr_en, cmd_rd_en, rsp_wr_en, rsp_rd_en, cmd_clr, rsp_clr, dev_rst, self_rst;

  int n_checks = 0, n_fail = 0;
  int push_cnt = 0, pop_cnt = 0;
  logic [31:0] last_cmd = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rword(input int n);
    return 32'h1122_3344 + 32'(n) * 32'h0102_0305;
  endfunction

  assign rsp_data = rword(pop_cnt);

  always @(posedge clk) begin
    if (cmd_valid && cmd_ready) begin
      push_cnt <= push_cnt + 1;
      last_cmd <= cmd_data;
    end
    if (rsp_ready && rsp_valid) pop_cnt <= pop_cnt + 1;
  end

  hostreg_word_bridge #(.NBYTES(NB)) i_hostreg_word_bridge (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_rd(addr_rd),
    .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte), .rd_byte(rd_byte),
    .proto_err(proto_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_empty(cmd_empty), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_full(rsp_full),
    .cmd_wr_en(cmd_wr_en), .cmd_rd_en(cmd_rd_en), .rsp_wr_en(rsp_wr_en),
    .rsp_rd_en(rsp_rd_en), .cmd_clr(cmd_clr), .rsp_clr(rsp_clr),
    .dev_rst(dev_rst), .self_rst(self_rst)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic set_addr(input logic [7:0] a);
    addr_wr = 1; wr_byte = a; cyc(); addr_wr = 0;
  endtask

  task automatic get_addr(output logic [7:0] v);
    addr_rd = 1; cyc(); addr_rd = 0; v = rd_byte;
  endtask

  task automatic dwrite(input logic [7:0] b);
    data_wr = 1; wr_byte = b; cyc(); data_wr = 0;
  endtask

  task automatic dread(output logic [7:0] v);
    data_rd = 1; cyc(); data_rd = 0; v = rd_byte;
  endtask

  function automatic logic [7:0] stat_exp(input bit e);
    return {e, 3'b000, rsp_full, ~rsp_valid, ~cmd_ready, cmd_empty};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [31:0] w;
    int p0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // R1 reset state
    chk(rd_byte == 0 && !cmd_valid && !rsp_ready, "R1 outputs idle", {24'h0, rd_byte}, 32'h0);
    chk({cmd_wr_en, cmd_rd_en, rsp_wr_en, rsp_rd_en, cmd_clr, rsp_clr, dev_rst, self_rst} == 8'h00,
        "R1 controls low", {24'h0, cmd_wr_en, cmd_rd_en, rsp_wr_en, rsp_rd_en, cmd_clr, rsp_clr, dev_rst, self_rst}, 32'h0);
    get_addr(v);
    chk(v == 8'h00, "R1 pointer zero", {24'h0, v}, 32'h0);
    dread(v);
    chk(v == 8'h00, "R1 control zero", {24'h0, v}, 32'h0);

    // R2 pointer sweep through address cycles
    for (int a = 0; a < 256; a += 17) begin
      set_addr(8'(a));
      get_addr(v);
      chk(v == 8'(a), "R2 pointer readback", {24'h0, v}, a);
    end

    // R3 control register: all enable patterns plus clear pulses
    set_addr(P_CTRL);
    for (int e = 0; e < 16; e++) begin
      dwrite({2'b00, e[1:0], e[3:0]});
      chk({rsp_rd_en, rsp_wr_en, cmd_rd_en, cmd_wr_en} == e[3:0], "R3 enable pins",
          {28'h0, rsp_rd_en, rsp_wr_en, cmd_rd_en, cmd_wr_en}, e);
      chk({rsp_clr, cmd_clr} == e[1:0], "R3 clear pulse", {30'h0, rsp_clr, cmd_clr}, e[1:0]);
      dread(v);
      chk(v == {4'h0, e[3:0]}, "R3 readback", {24'h0, v}, e[3:0]);
      chk({rsp_clr, cmd_clr} == 2'b00, "R3 clear one cycle", {30'h0, rsp_clr, cmd_clr}, 0);
    end

    // R4 status flag sweep
    dwrite(8'h00);
    set_addr(P_STAT);
    for (int f = 0; f < 16; f++) begin
      cmd_empty = f[0]; cmd_ready = ~f[1]; rsp_valid = ~f[2]; rsp_full = f[3];
      dread(v);
      chk(v == stat_exp(1'b0), "R4 status flags", {24'h0, v}, stat_exp(1'b0));
    end
    cmd_empty = 0; cmd_ready = 1; rsp_valid = 1; rsp_full = 0;

    // R5 command packing, several words
    set_addr(P_CTRL); dwrite(8'h01);
    set_addr(P_CMD);
    for (int k = 0; k < 8; k++) begin
      w = 32'hC0DE_0000 ^ (32'(k) * 32'h9E37_79B1);
      p0 = push_cnt;
      for (int b = 0; b < 4; b++) begin
        dwrite(w[8*b +: 8]);
        if (b < 3) chk(!cmd_valid, "R5 no early offer", {31'h0, cmd_valid}, 0);
      end
      chk(cmd_valid && cmd_data == w, "R5 word offered", cmd_data, w);
      cyc();
      chk(!cmd_valid, "R5 offer one cycle", {31'h0, cmd_valid}, 0);
      chk(push_cnt == p0 + 1 && last_cmd == w, "R5 word pushed", last_cmd, w);
    end

    // R6 dropped when disabled or not ready
    set_addr(P_CTRL); dwrite(8'h00);
    set_addr(P_CMD);
    p0 = push_cnt;
    for (int b = 0; b < 4; b++) dwrite(8'hA0 + 8'(b));
    chk(!cmd_valid, "R6 disabled no offer", {31'h0, cmd_valid}, 0);
    set_addr(P_CTRL); dwrite(8'h01);
    set_addr(P_CMD);
    cmd_ready = 0;
    for (int b = 0; b < 4; b++) dwrite(8'hB0 + 8'(b));
    cyc();
    cmd_ready = 1;
    cyc();
    chk(push_cnt == p0, "R6 no transfer", push_cnt, p0);

    // R7 response unpacking, consecutive words
    set_addr(P_CTRL); dwrite(8'h09);
    set_addr(P_RSP);
    for (int k = 0; k < 5; k++) begin
      p0 = pop_cnt;
      w = rword(p0);
      for (int b = 0; b < 4; b++) begin
        dread(v);
        chk(v == w[8*b +: 8], "R7 byte order", {24'h0, v}, w[8*b +: 8]);
        chk(pop_cnt == p0 + 1, "R7 one pop per word", pop_cnt, p0 + 1);
      end
    end

    // R8 empty FIFO and disabled read return zeros without popping
    rsp_valid = 0;
    p0 = pop_cnt;
    for (int b = 0; b < 4; b++) begin
      dread(v);
      chk(v == 8'h00, "R8 empty zeros", {24'h0, v}, 0);
    end
    rsp_valid = 1;
    set_addr(P_CTRL); dwrite(8'h01);
    set_addr(P_RSP);
    for (int b = 0; b < 4; b++) begin
      dread(v);
      chk(v == 8'h00, "R8 disabled zeros", {24'h0, v}, 0);
    end
    chk(pop_cnt == p0, "R8 no pop", pop_cnt, p0);

    // R9 short command run
    set_addr(P_CTRL); dwrite(8'h09);
    set_addr(P_CMD);
    dwrite(8'h55); dwrite(8'h66);
    set_addr(P_STAT);
    dread(v);
    chk(v == stat_exp(1'b0), "R9 error not yet visible", {24'h0, v}, stat_exp(1'b0));
    dread(v);
    chk(v == stat_exp(1'b1), "R9 short run flagged", {24'h0, v}, stat_exp(1'b1));
    dwrite(8'h80);
    dread(v);
    chk(v == stat_exp(1'b0), "R10 write-one clears", {24'h0, v}, stat_exp(1'b0));
    dread(v);
    chk(v == stat_exp(1'b0), "R10 stays clear", {24'h0, v}, stat_exp(1'b0));
    set_addr(P_CMD);
    p0 = push_cnt;
    w = 32'h0403_0201;
    for (int b = 0; b < 4; b++) dwrite(w[8*b +: 8]);
    cyc();
    chk(push_cnt == p0 + 1 && last_cmd == w, "R9 restart at byte 0", last_cmd, w);

    // R9 short response run
    set_addr(P_RSP);
    p0 = pop_cnt;
    dread(v);
    set_addr(P_STAT);
    dread(v);
    dread(v);
    chk(v == stat_exp(1'b1), "R9 short read flagged", {24'h0, v}, stat_exp(1'b1));
    set_addr(P_RSP);
    w = rword(p0 + 1);
    for (int b = 0; b < 4; b++) begin
      dread(v);
      chk(v == w[8*b +: 8], "R9 read restarts with new pop", {24'h0, v}, w[8*b +: 8]);
    end

    // R10 sticky error and protocol error input
    set_addr(P_STAT);
    dread(v);
    chk(v == stat_exp(1'b1), "R10 sticky", {24'h0, v}, stat_exp(1'b1));
    dwrite(8'h7F);
    dread(v);
    chk(v == stat_exp(1'b1), "R10 bit7 low keeps error", {24'h0, v}, stat_exp(1'b1));
    dwrite(8'h80);
    proto_err = 1; cyc(); proto_err = 0;
    dread(v);
    chk(v == stat_exp(1'b1), "R10 protocol error sets", {24'h0, v}, stat_exp(1'b1));
    proto_err = 1; data_wr = 1; wr_byte = 8'h80; cyc(); data_wr = 0; proto_err = 0;
    dread(v);
    chk(v == stat_exp(1'b1), "R10 set wins over clear", {24'h0, v}, stat_exp(1'b1));

    // R11 device reset and self reset
    set_addr(P_RST);
    dwrite(8'h01);
    chk(dev_rst == 1'b1, "R11 device reset on", {31'h0, dev_rst}, 1);
    dread(v);
    chk(v == 8'h01, "R11 reset readback", {24'h0, v}, 1);
    dwrite(8'h02);
    chk(self_rst == 1'b1, "R11 self reset pulse", {31'h0, self_rst}, 1);
    cyc();
    chk(!self_rst && !dev_rst && !cmd_wr_en && !rsp_rd_en, "R11 defaults restored",
        {28'h0, self_rst, dev_rst, cmd_wr_en, rsp_rd_en}, 0);
    get_addr(v);
    chk(v == 8'h00, "R11 pointer cleared", {24'h0, v}, 0);
    set_addr(P_STAT);
    dread(v);
    chk(v == stat_exp(1'b0), "R11 error cleared", {24'h0, v}, stat_exp(1'b0));

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule